// File: doc/BRIEF.md
# I2C bus status flag register

An 8-bit flag register for the master side of an I2C controller. It keeps a bus-busy flag up to date from single-cycle start-detected and stop-detected pulses, and it holds two configuration bits. The first is a one-shot start-enable trigger, which decides whether the master may issue a start right after the controller is enabled. The second is a reservation-disable bit. A sticky start-failed flag records that a requested start could not be issued.

Software reaches the register through a write port. A write either updates the whole byte or sets one selected bit to a given value. The read value is always presented on a byte-wide output. The master logic takes the busy flag, the configuration bits and a start-permitted indication directly from dedicated outputs. Line handling and condition detection are outside this block.

Top module: `i2c_busflag_reg`

## Requirements
- R1: An active-low asynchronous reset clears the whole register, so the read value is 0x00.
- R2: The read value carries start-failed in bit 7, bus-busy in bit 6, start-enable in bit 1 and reservation-disable in bit 0. Bits 5:2 always read as zero.
- R3: When a start is detected and no stop is detected, bus-busy reads 1 in the next cycle. When a stop is detected, bus-busy reads 0 in the next cycle.
- R4: When a start and a stop are detected in the same cycle, bus-busy reads 0 afterwards.
- R5: When the controller enable goes from 0 to 1 while start-enable is 0, bus-busy is set.
- R6: When the controller enable goes from 0 to 1 while start-enable is 1, bus-busy keeps its value.
- R7: A detected start clears start-enable. This takes priority over a software write to that bit in the same cycle.
- R8: A start-not-issued event sets start-failed only while reservation-disable (bit 0) is 1. While bit 0 is 0 the event has no effect.
- R9: Writing 1 to the start-request bit clears start-failed. Writing 0 to it leaves start-failed unchanged. If a setting event arrives in the same cycle as the clearing write, start-failed ends up set.
- R10: While the controller enable is 1, software writes leave bits 1 and 0 unchanged. Bits 7, 6 and 5:2 never take a software write.
- R11: In byte mode (wr_bit_mode_i = 0) a write takes bits 1:0 from wr_data_i[1:0]. In bit mode (wr_bit_mode_i = 1) only the bit indexed by wr_bit_sel_i changes, and it takes the value of wr_data_i[0].
- R12: start_permit_o is 1 exactly when bus-busy is 0 or start-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Controller enable level |
| start_det_i | input | 1 | Start condition detected (one-cycle pulse) |
| stop_det_i | input | 1 | Stop condition detected (one-cycle pulse) |
| start_not_issued_i | input | 1 | A requested start was not issued and its request bit was dropped |
| start_req_wr_i | input | 1 | Software write strobe for the start-request bit |
| start_req_wdata_i | input | 1 | Value written to the start-request bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_bit_mode_i | input | 1 | 0 selects a byte write, 1 selects a single-bit write |
| wr_bit_sel_i | input | 3 | Bit index for a single-bit write |
| wr_data_i | input | 8 | Write data; bit 0 is the value in bit mode |
| rd_data_o | output | 8 | Register read value |
| bus_busy_o | output | 1 | Bus-busy flag |
| start_fail_o | output | 1 | Start-failed flag |
| start_en_o | output | 1 | Start-enable trigger bit |
| rsv_dis_o | output | 1 | Reservation-disable bit |
| start_permit_o | output | 1 | The master may generate a start condition |

## Verification
Every flag is held in a register that updates on the clock edge where its event or write is sampled. Each result is therefore due one cycle after its stimulus, and both rd_data_o and start_permit_o follow as combinational functions of those registers. The driver applies one stimulus at each falling edge and pushes the expected register byte and permit bit into a queue. The monitor pops that entry one time unit after the next rising edge, which is exactly the cycle the result is due. Events that coincide in one cycle, such as start with stop, start with a write, or a set event with a clear write, are driven in the same stimulus so that the priority order is what gets checked.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned SEL_W  = $clog2(REG_W);
  localparam int unsigned B_FAIL = 7;
  localparam int unsigned B_BUSY = 6;
  localparam int unsigned B_STEN = 1;
  localparam int unsigned B_RSV  = 0;
  localparam int unsigned CFG_N  = 2;  // lockable config bits live at [CFG_N-1:0]

  typedef struct packed {
    logic [CFG_N-1:0] we;
    logic [CFG_N-1:0] val;
  } cfg_wr_t;

  // Per-bit write enables and values for the lockable config bits.
  function automatic cfg_wr_t decode_cfg_wr(
    input logic             wr,
    input logic             locked,
    input logic             bit_mode,
    input logic [SEL_W-1:0] sel,
    input logic [CFG_N-1:0] dat_lo,
    input logic             dat_bit
  );
    cfg_wr_t r;
    for (int b = 0; b < CFG_N; b++) begin
      r.we[b]  = wr && !locked && (!bit_mode || (sel == SEL_W'(b)));
      r.val[b] = bit_mode ? dat_bit : dat_lo[b];
    end
    return r;
  endfunction
endpackage

// File: rtl/i2c_bus_busy_trk.sv
module i2c_bus_busy_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_en_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic start_en_i,
  output logic busy_o
);
  logic en_q, busy_q, en_rise;

  assign en_rise = ctrl_en_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      en_q <= ctrl_en_i;
      if (stop_det_i)                   busy_q <= 1'b0;  // stop wins
      else if (start_det_i)             busy_q <= 1'b1;
      else if (en_rise && !start_en_i)  busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;

  p_busy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i && !stop_det_i |=> busy_o);
  p_stop_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !busy_o);
  p_en_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i && !en_q && !start_en_i && !stop_det_i |=> busy_o);
  p_en_rise_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i && !en_q && start_en_i && !stop_det_i && !start_det_i |=> $stable(busy_o));
endmodule

// File: rtl/i2c_cfg_bits.sv
module i2c_cfg_bits
  import i2c_flag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ctrl_en_i,
  input  logic    start_det_i,
  input  cfg_wr_t wr_i,
  output logic    start_en_o,
  output logic    rsv_dis_o
);
  logic [CFG_N-1:0] cfg_q;

  for (genvar b = 0; b < CFG_N; b++) begin : g_cfg
    if (b == B_STEN) begin : g_sten
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cfg_q[b] <= 1'b0;
        else if (start_det_i) cfg_q[b] <= 1'b0;  // one-shot, hw wins
        else if (wr_i.we[b])  cfg_q[b] <= wr_i.val[b];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cfg_q[b] <= 1'b0;
        else if (wr_i.we[b]) cfg_q[b] <= wr_i.val[b];
      end
    end
  end

  assign start_en_o = cfg_q[B_STEN];
  assign rsv_dis_o  = cfg_q[B_RSV];

  p_sten_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> !start_en_o);
  p_sten_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i && !start_det_i |=> $stable(start_en_o));
  p_rsv_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i |=> $stable(rsv_dis_o));
endmodule

// File: rtl/i2c_start_fail_flag.sv
module i2c_start_fail_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_not_issued_i,
  input  logic rsv_dis_i,
  input  logic start_req_wr_i,
  input  logic start_req_wdata_i,
  output logic fail_o
);
  logic fail_q, set_ev, clr_ev;

  assign set_ev = start_not_issued_i && rsv_dis_i;
  assign clr_ev = start_req_wr_i && start_req_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fail_q <= 1'b0;
    else if (set_ev) fail_q <= 1'b1;  // set beats clear
    else if (clr_ev) fail_q <= 1'b0;
  end

  assign fail_o = fail_q;

  p_fail_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_not_issued_i && rsv_dis_i |=> fail_o);
  p_fail_ign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsv_dis_i && !(start_req_wr_i && start_req_wdata_i) |=> $stable(fail_o));
  p_fail_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_wr_i && start_req_wdata_i && !(start_not_issued_i && rsv_dis_i) |=> !fail_o);
endmodule

// File: rtl/i2c_busflag_reg.sv
module i2c_busflag_reg
  import i2c_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_en_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             start_not_issued_i,
  input  logic             start_req_wr_i,
  input  logic             start_req_wdata_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_mode_i,
  input  logic [SEL_W-1:0] wr_bit_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             bus_busy_o,
  output logic             start_fail_o,
  output logic             start_en_o,
  output logic             rsv_dis_o,
  output logic             start_permit_o
);
  cfg_wr_t cfg_wr;
  logic    unused_wdata;

  assign unused_wdata = ^wr_data_i[REG_W-1:CFG_N];

  assign cfg_wr = decode_cfg_wr(wr_en_i, ctrl_en_i, wr_bit_mode_i, wr_bit_sel_i,
                                wr_data_i[CFG_N-1:0], wr_data_i[0]);

  i2c_bus_busy_trk u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_en_i  (ctrl_en_i),
    .start_det_i(start_det_i),
    .stop_det_i (stop_det_i),
    .start_en_i (start_en_o),
    .busy_o     (bus_busy_o)
  );

  i2c_cfg_bits u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_en_i  (ctrl_en_i),
    .start_det_i(start_det_i),
    .wr_i       (cfg_wr),
    .start_en_o (start_en_o),
    .rsv_dis_o  (rsv_dis_o)
  );

  i2c_start_fail_flag u_fail (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .start_not_issued_i(start_not_issued_i),
    .rsv_dis_i         (rsv_dis_o),
    .start_req_wr_i    (start_req_wr_i),
    .start_req_wdata_i (start_req_wdata_i),
    .fail_o            (start_fail_o)
  );

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[B_FAIL] = start_fail_o;
    rd_data_o[B_BUSY] = bus_busy_o;
    rd_data_o[B_STEN] = start_en_o;
    rd_data_o[B_RSV]  = rsv_dis_o;
  end

  assign start_permit_o = !bus_busy_o || start_en_o;

  // Status bits take no software write.
  p_ro_fail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !start_not_issued_i && !start_req_wr_i |=> $stable(start_fail_o));
  p_ro_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !start_det_i && !stop_det_i && $stable(ctrl_en_i) |=> $stable(bus_busy_o));
endmodule

// File: tb/tb_i2c_busflag_reg.sv
`timescale 1ns/1ps
module tb_i2c_busflag_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sd = 0, pd = 0, sni = 0, srw = 0, srd = 0, wr = 0, bm = 0;
  logic [2:0] sel = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic busy, fail, sten, rsv, permit;

  always #2 clk = ~clk;  // 250 MHz

  i2c_busflag_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(en), .start_det_i(sd), .stop_det_i(pd),
    .start_not_issued_i(sni), .start_req_wr_i(srw), .start_req_wdata_i(srd),
    .wr_en_i(wr), .wr_bit_mode_i(bm), .wr_bit_sel_i(sel), .wr_data_i(wd),
    .rd_data_o(rd), .bus_busy_o(busy), .start_fail_o(fail), .start_en_o(sten),
    .rsv_dis_o(rsv), .start_permit_o(permit)
  );

  typedef struct { logic [7:0] val; logic perm; string req; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic m_busy = 0, m_sten = 0, m_rsv = 0, m_fail = 0, m_enq = 0;

  task automatic step(input string req, input logic e, input logic s, input logic p,
                      input logic n, input logic rw, input logic rdat, input logic w,
                      input logic b, input logic [2:0] bs, input logic [7:0] d);
    logic [7:0] mask, dat;
    logic nb, ns, nr, nf;
    exp_t x;
    @(negedge clk);
    en = e; sd = s; pd = p; sni = n; srw = rw; srd = rdat; wr = w; bm = b; sel = bs; wd = d;
    mask = b ? (8'h01 << bs) : 8'hff;
    dat  = b ? {8{d[0]}} : d;
    nb = p ? 1'b0 : s ? 1'b1 : (e && !m_enq && !m_sten) ? 1'b1 : m_busy;
    ns = s ? 1'b0 : (w && !e && mask[1]) ? dat[1] : m_sten;
    nr = (w && !e && mask[0]) ? dat[0] : m_rsv;
    nf = (n && m_rsv) ? 1'b1 : (rw && rdat) ? 1'b0 : m_fail;
    m_busy = nb; m_sten = ns; m_rsv = nr; m_fail = nf; m_enq = e;
    x.val = {m_fail, m_busy, 4'b0, m_sten, m_rsv};
    x.perm = !m_busy || m_sten;
    x.req = req;
    q.push_back(x);
  endtask

  task automatic idle(input string req, input logic e);
    step(req, e, 0, 0, 0, 0, 0, 0, 0, 3'd0, 8'h00);
  endtask

  // monitor: result due one cycle after each stimulus
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (rd !== x.val || permit !== x.perm) begin
        errors++;
        $display("FAIL %s: rd=%h permit=%b expected rd=%h permit=%b", x.req, rd, permit, x.val, x.perm);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rd !== 8'h00 || permit !== 1'b1) begin
      errors++;
      $display("FAIL R1: rd=%h permit=%b expected rd=00 permit=1", rd, permit);
    end
    @(negedge clk) rst_n = 1'b1;

    // R2/R10: byte write of all ones lands only in bits 1:0
    step("R2", 0,0,0,0,0,0, 1,0,3'd0, 8'hff);
    // R11: bit writes
    step("R11", 0,0,0,0,0,0, 1,1,3'd0, 8'h00);
    step("R11", 0,0,0,0,0,0, 1,1,3'd6, 8'h01);
    step("R11", 0,0,0,0,0,0, 1,1,3'd0, 8'h01);
    step("R11", 0,0,0,0,0,0, 1,0,3'd0, 8'h00);
    // R5: enable with start-enable clear forces busy
    idle("R5", 1);
    // R10: locked config
    step("R10", 1,0,0,0,0,0, 1,0,3'd0, 8'h03);
    step("R10", 1,0,0,0,0,0, 1,1,3'd1, 8'h01);
    // R3, R4
    step("R3", 1,0,1,0,0,0, 0,0,3'd0, 8'h00);
    step("R3", 1,1,0,0,0,0, 0,0,3'd0, 8'h00);
    step("R4", 1,1,1,0,0,0, 0,0,3'd0, 8'h00);
    // R6: enable with start-enable set keeps busy clear
    idle("R6", 0);
    step("R6", 0,0,0,0,0,0, 1,0,3'd0, 8'h02);
    idle("R6", 1);
    // R7: start clears start-enable
    step("R7", 1,1,0,0,0,0, 0,0,3'd0, 8'h00);
    idle("R12", 0);
    // R7: start beats simultaneous write
    step("R7", 0,1,0,0,0,0, 1,1,3'd1, 8'h01);
    // R12: busy and start-enable both set
    step("R12", 0,0,0,0,0,0, 1,1,3'd1, 8'h01);
    step("R12", 0,0,1,0,0,0, 1,0,3'd0, 8'h00);
    // R8
    step("R8", 0,0,0,1,0,0, 0,0,3'd0, 8'h00);
    step("R8", 0,0,0,0,0,0, 1,0,3'd0, 8'h01);
    step("R8", 0,0,0,1,0,0, 0,0,3'd0, 8'h00);
    step("R10", 0,0,0,0,0,0, 1,1,3'd7, 8'h00);
    // R9
    step("R9", 0,0,0,0,1,0, 0,0,3'd0, 8'h00);
    step("R9", 0,0,0,0,1,1, 0,0,3'd0, 8'h00);
    step("R9", 0,0,0,1,1,1, 0,0,3'd0, 8'h00);
    step("R9", 0,0,0,0,1,1, 0,0,3'd0, 8'h00);
    idle("R2", 0);
    idle("R2", 0);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule